// File: doc/BRIEF.md
# Programmable Reference Clock Generator

The block produces a reference clock from one of nine clock inputs. A select field picks the source. A glitch-free handover stage switches between sources, and a counter divides the chosen clock by an even ratio. The divided clock can also be sent to an output pin. Software controls everything through one 32-bit control word, written and read on a bus clock.

The divisor field gives the half period in source cycles, so a value N produces one output period every 2·N source periods. N = 0 passes the selected clock straight through.

A divisor written while the clock is running is held back. It takes effect only after software raises the switch flag. Hardware loads the new value at the end of a full output period, and then clears the flag.

Enable, debug freeze, stop-in-idle and stop-in-sleep all gate the output, and a gated output rests low. The sleep gate is bypassed when the select field is 0 or 1.

Top module: `refclk_gen`

## Requirements
- R1: After reset the control word reads 0x00000000, and both refClkOut and pinOut are low.
- R2: The control word has this layout:
  - bits 30:16 hold the divisor N;
  - bit 15 is enable, bit 14 is freeze in debug, bit 13 is stop in idle, bit 12 is pin enable, bit 11 is run in sleep;
  - bit 9 is the switch flag and bit 8 is the read-only active flag;
  - bits 3:0 hold the source select;
  - bits 31, 10 and 7:4 read as 0.
- R3: With N > 0 and the module running, the refClkOut period is exactly 2·N periods of the selected source.
- R4: With N = 0 and the module running, refClkOut has the same period as the selected source.
- R5: Select code k in 0..8 picks srcClk[k]. A code of 9..15 keeps refClkOut low.
- R6: While the enable bit is 0, refClkOut stays low. The active flag reads 1 only after enable has reached the selected clock domain, and it returns to 0 after disable has reached that domain.
- R7: pinOut follows refClkOut when the pin enable bit is 1, and is held low when that bit is 0.
- R8: With sleepIn = 1 and run in sleep = 0, refClkOut stops low for select codes 2..8. For codes 0 and 1, and whenever run in sleep = 1, sleep has no effect.
- R9: With stop in idle = 1, idleIn = 1 stops refClkOut low. With stop in idle = 0, idleIn has no effect.
- R10: With freeze = 1, debugIn = 1 stops refClkOut low. With freeze = 0, debugIn has no effect.
- R11: A divisor written while running leaves the period unchanged. Writing 1 to bit 9 sets the switch flag, which reads 1 until hardware clears it. After that the period is 2·N of the new divisor, with no runt cycle. While the module is stopped, a raised flag is cleared without waiting for a period boundary.
- R12: At any time at most one source clock is gated through to the divider. After a source change, the output period follows the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Clock for the control word |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write strobe for the control word |
| regWrData | input | 32 | Value to write |
| regRdData | output | 32 | Current control word, including status bits |
| srcClk | input | 9 | Candidate source clocks, indexed by select code |
| sleepIn | input | 1 | Device is in sleep |
| idleIn | input | 1 | Device is idle |
| debugIn | input | 1 | Debugger holds the device |
| refClkOut | output | 1 | Divided reference clock |
| pinOut | output | 1 | Pin drive of the reference clock |

## Verification
The hardest case to reach is the divider switch. The new divisor must wait for a period boundary in the source domain while the module keeps running, and the flag must be seen as 1 before the round trip clears it. The bench starts the clock with one divisor and confirms its period. It then writes a second divisor without the flag and checks that the period has not changed. Next it sets the flag and reads it back on the very next bus cycle, then polls until hardware clears it. Finally it measures the period again and expects the new ratio exactly.

// File: rtl/refclk_pkg.sv
`timescale 1ns/1ps
package refclk_pkg;
  localparam int DIV_W   = 15;
  localparam int SEL_W   = 4;
  localparam int NUM_SRC = 9;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic             on;
    logic             run;
    logic             oe;
    logic             swReq;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/refclk_ctrl.sv
`timescale 1ns/1ps
module refclk_ctrl
  import refclk_pkg::*;
(
  input  logic        busClk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [31:0] regWrData,
  input  logic        sleepIn,
  input  logic        idleIn,
  input  logic        debugIn,
  input  logic        onDom,
  input  logic        ackDom,
  output logic [31:0] regRdData,
  output ctrl_t       ctrl
);
  localparam int DIV_LSB = 16;
  localparam int SEL_LSB = 0;

  logic [DIV_W-1:0] divReg;
  logic [SEL_W-1:0] selReg;
  logic onReg, frzReg, sidlReg, oeReg, rslpReg, swReq;
  logic [1:0] ackSync, actSync;
  logic ackD, ackRise, sleepGate, runNow;
  logic unusedWrBits;

  assign unusedWrBits = ^{regWrData[31], regWrData[10], regWrData[8:4]};

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= '0;
      selReg  <= '0;
      onReg   <= 1'b0;
      frzReg  <= 1'b0;
      sidlReg <= 1'b0;
      oeReg   <= 1'b0;
      rslpReg <= 1'b0;
      swReq   <= 1'b0;
      ackSync <= '0;
      actSync <= '0;
      ackD    <= 1'b0;
    end else begin
      ackSync <= {ackSync[0], ackDom};
      actSync <= {actSync[0], onDom};
      ackD    <= ackSync[1];
      if (regWr) begin
        divReg  <= regWrData[DIV_LSB +: DIV_W];
        onReg   <= regWrData[15];
        frzReg  <= regWrData[14];
        sidlReg <= regWrData[13];
        oeReg   <= regWrData[12];
        rslpReg <= regWrData[11];
        selReg  <= regWrData[SEL_LSB +: SEL_W];
      end
      if (regWr && regWrData[9]) swReq <= 1'b1;
      else if (ackRise)          swReq <= 1'b0;
    end
  end

  assign ackRise   = ackSync[1] & ~ackD;
  assign sleepGate = sleepIn && !rslpReg && (selReg > SEL_W'(1));
  assign runNow    = onReg && !(frzReg && debugIn) && !(sidlReg && idleIn) && !sleepGate;

  assign ctrl.on    = onReg;
  assign ctrl.run   = runNow;
  assign ctrl.oe    = oeReg;
  assign ctrl.swReq = swReq;
  assign ctrl.sel   = selReg;
  assign ctrl.div   = divReg;

  assign regRdData = {1'b0, divReg, onReg, frzReg, sidlReg, oeReg, rslpReg,
                      1'b0, swReq, actSync[1], 4'b0000, selReg};

  // R11: the flag can only drop after an acknowledge has come back
  a_r11_flag_needs_ack: assert property (@(posedge busClk) disable iff (!rstN)
    (swReq && !ackSync[1]) |=> swReq);
endmodule

// File: rtl/refclk_dp.sv
`timescale 1ns/1ps
module refclk_dp
  import refclk_pkg::*;
(
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcClk,
  input  ctrl_t              ctrl,
  output logic               onDom,
  output logic               ackDom,
  output logic               refClk,
  output logic               pinOut
);
  logic [NUM_SRC-1:0] srcOn;
  logic [NUM_SRC-1:0] gated;
  logic divClk;

  // glitch-free handover: each source arms only when all others are off
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    logic s1, s2, want;
    assign want = (ctrl.sel == SEL_W'(i)) &&
                  ((srcOn & ~(NUM_SRC'(1) << i)) == '0);
    always_ff @(negedge srcClk[i] or negedge rstN) begin
      if (!rstN) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= want;
        s2 <= s1;
      end
    end
    assign srcOn[i] = s2;
    assign gated[i] = srcClk[i] & s2;
  end

  assign divClk = |gated;

  always_comb begin
    a_r12_one_source: assert ($onehot0(srcOn));
  end

  logic [1:0] onS, runS, reqS;
  logic runDom, reqDom, tog, ack, passEn, atEnd;
  logic [DIV_W-1:0] workDiv, cnt;

  assign runDom = runS[1];
  assign reqDom = reqS[1];
  assign atEnd  = (workDiv == '0) || ((cnt == workDiv - 1'b1) && tog);

  always_ff @(posedge divClk or negedge rstN) begin
    if (!rstN) begin
      onS     <= '0;
      runS    <= '0;
      reqS    <= '0;
      workDiv <= '0;
      cnt     <= '0;
      tog     <= 1'b0;
      ack     <= 1'b0;
    end else begin
      onS  <= {onS[0],  ctrl.on};
      runS <= {runS[0], ctrl.run};
      reqS <= {reqS[0], ctrl.swReq};
      if (!runDom) begin
        cnt     <= '0;
        tog     <= 1'b0;
        workDiv <= ctrl.div;
        ack     <= reqDom;
      end else if (reqDom && !ack && atEnd) begin
        workDiv <= ctrl.div;
        cnt     <= '0;
        tog     <= 1'b0;
        ack     <= 1'b1;
      end else begin
        if (!reqDom) ack <= 1'b0;
        if (workDiv != '0) begin
          if (cnt == workDiv - 1'b1) begin
            cnt <= '0;
            tog <= ~tog;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(negedge divClk or negedge rstN) begin
    if (!rstN) passEn <= 1'b0;
    else       passEn <= runDom && (workDiv == '0);
  end

  assign onDom  = onS[1];
  assign ackDom = ack;
  assign refClk = ((divClk & passEn) | tog) & (ctrl.sel < SEL_W'(NUM_SRC));
  assign pinOut = refClk & ctrl.oe;

  a_r11_div_held: assert property (@(posedge divClk) disable iff (!rstN)
    (runDom && !reqDom) |=> $stable(workDiv));
  a_r6_stop_low: assert property (@(posedge divClk) disable iff (!rstN)
    !runDom |=> !tog);
  a_r3_cnt_bound: assert property (@(posedge divClk) disable iff (!rstN)
    (workDiv != '0) |-> (cnt < workDiv));
endmodule

// File: rtl/refclk_gen.sv
`timescale 1ns/1ps
module refclk_gen
  import refclk_pkg::*;
(
  input  logic               busClk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               sleepIn,
  input  logic               idleIn,
  input  logic               debugIn,
  output logic               refClkOut,
  output logic               pinOut
);
  ctrl_t ctrl;
  logic onDom, ackDom;

  refclk_ctrl u_ctrl (
    .busClk(busClk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData),
    .sleepIn(sleepIn), .idleIn(idleIn), .debugIn(debugIn),
    .onDom(onDom), .ackDom(ackDom), .regRdData(regRdData), .ctrl(ctrl)
  );

  refclk_dp u_dp (
    .rstN(rstN), .srcClk(srcClk), .ctrl(ctrl), .onDom(onDom),
    .ackDom(ackDom), .refClk(refClkOut), .pinOut(pinOut)
  );
endmodule

// File: tb/refclk_gen_tb.sv
`timescale 1ns/1ps
module refclk_gen_tb;
  logic busClk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [8:0] srcClk;
  logic sleepIn = 1'b0, idleIn = 1'b0, debugIn = 1'b0;
  logic refClkOut, pinOut;

  localparam int HALF [9] = '{4, 6, 7, 9, 11, 13, 15, 17, 20};

  int nChecks = 0, nFails = 0;
  int refEdges = 0, pinEdges = 0;
  realtime lastT = 0, prevT = 0;
  logic [31:0] curWord = '0;

  always #5 busClk = ~busClk;

  for (genvar g = 0; g < 9; g++) begin : gClk
    logic c = 1'b0;
    initial forever #(HALF[g]) c = ~c;
    assign srcClk[g] = c;
  end

  refclk_gen u_dut (
    .busClk(busClk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .srcClk(srcClk), .sleepIn(sleepIn),
    .idleIn(idleIn), .debugIn(debugIn), .refClkOut(refClkOut), .pinOut(pinOut)
  );

  always @(posedge refClkOut) begin
    prevT = lastT;
    lastT = $realtime;
    refEdges++;
  end
  always @(posedge pinOut) pinEdges++;

  function automatic logic [31:0] cfg(bit on, bit frz, bit sidl, bit oe, bit rslp,
                                      bit sw, int sel, int div);
    cfg = {1'b0, div[14:0], on, frz, sidl, oe, rslp, 1'b0, sw, 1'b0, 4'b0000, sel[3:0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [31:0] w);
    @(negedge busClk);
    regWr = 1'b1;
    regWrData = w;
    @(negedge busClk);
    regWr = 1'b0;
  endtask

  task automatic waitActive(bit v);
    for (int k = 0; k < 500; k++) begin
      if (regRdData[8] == v) break;
      @(negedge busClk);
    end
  endtask

  task automatic runCfg(logic [31:0] w);
    logic [31:0] off;
    off = curWord;
    off[15] = 1'b0;
    off[9] = 1'b0;
    writeReg(off);
    waitActive(1'b0);
    writeReg(w);
    if (w[15]) waitActive(1'b1);
    curWord = w;
  endtask

  task automatic measure(output int per);
    int e0;
    e0 = refEdges;
    per = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge busClk);
      if (refEdges >= e0 + 3) begin
        per = $rtoi(lastT - prevT + 0.5);
        break;
      end
    end
  endtask

  task automatic countEdges(int cycles, output int nRef, output int nPin);
    int r0, p0;
    r0 = refEdges;
    p0 = pinEdges;
    repeat (cycles) @(negedge busClk);
    nRef = refEdges - r0;
    nPin = pinEdges - p0;
  endtask

  initial begin
    #1_500_000;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int per, nr, np;
    int divs [4] = '{0, 1, 2, 5};
    repeat (3) @(negedge busClk);
    // R1 reset state
    check(regRdData == 32'h0, "R1 reset word", regRdData, 0);
    check(refClkOut == 1'b0, "R1 refClkOut low", refClkOut, 0);
    check(pinOut == 1'b0, "R1 pinOut low", pinOut, 0);
    rstN = 1'b1;
    repeat (3) @(negedge busClk);

    // R2 layout: enable clear, every writable field set
    writeReg(32'hFFFF_7FFF);
    check(regRdData == 32'h7FFF_7A0F, "R2 readback", regRdData, 32'h7FFF7A0F);
    // R11 stopped: flag clears without a period boundary
    writeReg(cfg(0, 0, 0, 1, 0, 0, 0, 1));
    for (int k = 0; k < 200 && regRdData[9]; k++) @(negedge busClk);
    check(regRdData[9] == 1'b0, "R11 flag cleared while stopped", regRdData[9], 0);
    curWord = cfg(0, 0, 0, 1, 0, 0, 0, 1);

    // R3 R4 R5 R12 sweep over every source and several divisors
    for (int s = 0; s < 9; s++) begin
      for (int d = 0; d < 4; d++) begin
        int expP;
        runCfg(cfg(1, 0, 0, 1, 0, 0, s, divs[d]));
        check(regRdData[8] == 1'b1, "R6 active after enable", regRdData[8], 1);
        measure(per);
        expP = (divs[d] == 0 ? 1 : 2 * divs[d]) * 2 * HALF[s];
        check(per == expP, divs[d] == 0 ? "R4 R5 R12 passthrough period" :
                                          "R3 R5 R12 divided period", per, expP);
      end
    end

    // R7 pin enable clear holds pin low
    runCfg(cfg(1, 0, 0, 0, 0, 0, 0, 2));
    countEdges(100, nr, np);
    check(np == 0 && nr > 0, "R7 pin held low", np, 0);
    runCfg(cfg(1, 0, 0, 1, 0, 0, 0, 2));
    countEdges(100, nr, np);
    check(np == nr && np > 0, "R7 pin follows clock", np, nr);

    // R6 disable stops output low and drops active
    runCfg(cfg(0, 0, 0, 1, 0, 0, 3, 1));
    repeat (10) @(negedge busClk);
    countEdges(100, nr, np);
    check(nr == 0 && refClkOut == 1'b0, "R6 disabled output low", nr, 0);
    check(regRdData[8] == 1'b0, "R6 active cleared", regRdData[8], 0);

    // R5 reserved select keeps output low
    runCfg(cfg(1, 0, 0, 1, 0, 0, 12, 0));
    repeat (20) @(negedge busClk);
    countEdges(200, nr, np);
    check(nr == 0 && refClkOut == 1'b0, "R5 reserved code low", nr, 0);
    runCfg(cfg(0, 0, 0, 1, 0, 0, 0, 1));

    // R8 sleep gating
    runCfg(cfg(1, 0, 0, 1, 0, 0, 2, 1));
    sleepIn = 1'b1;
    repeat (20) @(negedge busClk);
    countEdges(100, nr, np);
    check(nr == 0 && refClkOut == 1'b0, "R8 sleep stops source 2", nr, 0);
    sleepIn = 1'b0;
    measure(per);
    check(per == 4 * HALF[2], "R8 resumes after sleep", per, 4 * HALF[2]);
    for (int s = 0; s < 2; s++) begin
      runCfg(cfg(1, 0, 0, 1, 0, 0, s, 1));
      sleepIn = 1'b1;
      repeat (20) @(negedge busClk);
      measure(per);
      check(per == 4 * HALF[s], "R8 sleep ignored for code 0 or 1", per, 4 * HALF[s]);
      sleepIn = 1'b0;
    end
    runCfg(cfg(1, 0, 0, 1, 1, 0, 2, 1));
    sleepIn = 1'b1;
    repeat (20) @(negedge busClk);
    measure(per);
    check(per == 4 * HALF[2], "R8 run in sleep", per, 4 * HALF[2]);
    sleepIn = 1'b0;

    // R9 idle gating
    runCfg(cfg(1, 0, 1, 1, 0, 0, 1, 1));
    idleIn = 1'b1;
    repeat (20) @(negedge busClk);
    countEdges(100, nr, np);
    check(nr == 0 && refClkOut == 1'b0, "R9 idle stops", nr, 0);
    runCfg(cfg(1, 0, 0, 1, 0, 0, 1, 1));
    measure(per);
    check(per == 4 * HALF[1], "R9 idle ignored", per, 4 * HALF[1]);
    idleIn = 1'b0;

    // R10 debug freeze
    runCfg(cfg(1, 1, 0, 1, 0, 0, 5, 1));
    debugIn = 1'b1;
    repeat (20) @(negedge busClk);
    countEdges(100, nr, np);
    check(nr == 0 && refClkOut == 1'b0, "R10 debug freezes", nr, 0);
    runCfg(cfg(1, 0, 0, 1, 0, 0, 5, 1));
    measure(per);
    check(per == 4 * HALF[5], "R10 debug ignored", per, 4 * HALF[5]);
    debugIn = 1'b0;

    // R11 divider switch while running
    runCfg(cfg(1, 0, 0, 1, 0, 0, 4, 2));
    measure(per);
    check(per == 4 * 2 * HALF[4], "R11 initial period", per, 88);
    writeReg(cfg(1, 0, 0, 1, 0, 0, 4, 5));
    repeat (30) @(negedge busClk);
    measure(per);
    check(per == 4 * 2 * HALF[4], "R11 period held without flag", per, 88);
    check(regRdData[30:16] == 15'd5, "R11 divisor readback", regRdData[30:16], 5);
    writeReg(cfg(1, 0, 0, 1, 0, 1, 4, 5));
    check(regRdData[9] == 1'b1, "R11 flag reads set", regRdData[9], 1);
    for (int k = 0; k < 500 && regRdData[9]; k++) @(negedge busClk);
    check(regRdData[9] == 1'b0, "R11 flag cleared by hardware", regRdData[9], 0);
    measure(per);
    check(per == 10 * 2 * HALF[4], "R11 new period", per, 220);
    measure(per);
    check(per == 10 * 2 * HALF[4], "R11 new period steady", per, 220);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule